// File: doc/BRIEF.md
# CAN Transmit Queue Scheduler

This block holds a small pool of CAN frames waiting to be sent and decides which of them is handed next to a bit-level CAN controller. Each frame sits in one of a fixed number of slots, together with its identifier, payload, length and an 8-bit local priority. A two-bit configuration input picks one of four ordering policies: arrival order, lowest identifier first, lowest slot number first, or lowest local priority value first. Only one policy is active at a time. The policy can only change while the queue is empty.

Software or a higher protocol layer offers frames through a submit port. Each submission carries a replace flag. With the flag set, a waiting frame that has the same identifier and has not been granted is overwritten in place. This suits periodic value updates. With the flag clear, the new frame is queued behind any earlier frame with that identifier, and the earlier frame always leaves first. This suits segmented transfers. When the queue is full and no replace match exists, the submission is refused through a same-cycle busy signal.

The controller sees one candidate frame at a time. It takes the frame with a grant pulse. The granted frame is then locked until a done or abort pulse frees its slot. While a frame is locked, no other candidate is offered.

Top module: `can_txq_sched`

## Requirements
- R1: While reset is held, and after reset, `pending` is all zero, `full` is 0, `tx_valid` is 0 and `cur_mode` is 0.
- R2: The policy code sampled from `cfg_mode` (0 arrival, 1 identifier, 2 slot number, 3 local priority) is copied into `cur_mode` at a clock edge only when `pending` is all zero before that edge. Otherwise the code is ignored.
- R3: An accepted submission with no replace match goes into the lowest-numbered free slot. Its `pending` bit reads 1 after the next edge. `full` is 1 exactly when every `pending` bit is 1.
- R4: A submission made while `full` is 1 and with no replace match raises `sub_busy` in the same cycle, and the queue content is unchanged.
- R5: In mode 0, `tx_slot` names the eligible frame that was submitted earliest.
- R6: In mode 1, the eligible frame with the numerically lowest identifier is offered.
- R7: In mode 2, the lowest-numbered eligible slot is offered.
- R8: In mode 3, the lowest local priority value wins. Among equal priorities the lower identifier wins, and after that the earlier submission.
- R9: A submission with `sub_replace` set overwrites, in place, the most recently queued waiting frame that has the same identifier and is neither locked nor being granted that cycle. No new slot is taken and the frame's position in arrival order is kept.
- R10: In every mode, a frame is not eligible while an earlier-submitted frame with the same identifier is still pending.
- R11: `ctl_grant` while `tx_valid` is 1 locks the offered slot. `tx_valid` then stays 0 and the slot stays pending and cannot be replaced, until `ctl_done` or `ctl_abort` clears it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Requested ordering policy |
| sub_valid | input | 1 | Submission present this cycle |
| sub_id | input | ID_W | Identifier of the submitted frame |
| sub_data | input | DATA_W | Payload of the submitted frame |
| sub_len | input | LEN_W | Data length code |
| sub_prio | input | PRIO_W | Local priority, lower value is more urgent |
| sub_replace | input | 1 | Overwrite a waiting frame with the same identifier |
| sub_busy | output | 1 | Submission refused this cycle |
| tx_valid | output | 1 | A candidate frame is offered |
| tx_slot | output | SLOT_W | Slot of the offered frame |
| tx_id | output | ID_W | Identifier of the offered frame |
| tx_data | output | DATA_W | Payload of the offered frame |
| tx_len | output | LEN_W | Length of the offered frame |
| ctl_grant | input | 1 | Controller takes the offered frame |
| ctl_done | input | 1 | Locked frame sent, free its slot |
| ctl_abort | input | 1 | Locked frame dropped, free its slot |
| pending | output | NUM_SLOTS | Occupied-slot mask |
| full | output | 1 | All slots occupied |
| cur_mode | output | 2 | Active ordering policy |

## Verification
The candidate outputs (`tx_valid`, `tx_slot`, `tx_id`, `tx_data`, `tx_len`) depend only on the stored state, so they are compared in the same cycle as the state they describe. `sub_busy` follows the present inputs and is compared one time unit after they are driven, before the clock edge. `pending`, `full`, `cur_mode`, and the effects of grant, done, abort and replace become visible one edge after the stimulus. They are therefore compared on the falling edge that follows the rising edge that registers them. A bench model advances on that same edge, so every comparison lines up with the cycle in which the result is due.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;

   typedef enum logic [1:0] {
      TXQ_ARRIVAL   = 2'd0,
      TXQ_IDPRIO    = 2'd1,
      TXQ_SLOTORD   = 2'd2,
      TXQ_LOCALPRIO = 2'd3
   } txq_mode_e;

   localparam int unsigned TXQ_MODE_W = 2;

endpackage

// File: rtl/can_txq_store.sv
module can_txq_store #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ID_W      = 11,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned LEN_W     = 4,
   parameter int unsigned PRIO_W    = 8,
   parameter int unsigned SLOT_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_alloc,
   input  logic [SLOT_W-1:0]    wr_slot,
   input  logic [ID_W-1:0]      wr_id,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [LEN_W-1:0]     wr_len,
   input  logic [PRIO_W-1:0]    wr_prio,
   input  logic                 grant_en,
   input  logic [SLOT_W-1:0]    grant_slot,
   input  logic                 free_en,
   output logic [NUM_SLOTS-1:0] valid_o,
   output logic [NUM_SLOTS-1:0] lock_o,
   output logic [ID_W-1:0]      id_o    [NUM_SLOTS],
   output logic [DATA_W-1:0]    data_o  [NUM_SLOTS],
   output logic [LEN_W-1:0]     len_o   [NUM_SLOTS],
   output logic [PRIO_W-1:0]    prio_o  [NUM_SLOTS],
   output logic [NUM_SLOTS-1:0] older_o [NUM_SLOTS]
);

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      logic hit_wr;
      logic hit_grant;
      assign hit_wr    = wr_en && (wr_slot == SLOT_W'(k));
      assign hit_grant = grant_en && (grant_slot == SLOT_W'(k));

      // occupancy and lock state of slot k
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o[k] <= 1'b0;
            lock_o[k]  <= 1'b0;
         end else begin
            if (free_en && lock_o[k]) begin
               valid_o[k] <= 1'b0;
               lock_o[k]  <= 1'b0;
            end
            if (hit_grant) begin
               lock_o[k] <= 1'b1;
            end
            if (hit_wr && wr_alloc) begin
               valid_o[k] <= 1'b1;
               lock_o[k]  <= 1'b0;
            end
         end
      end

      // frame fields of slot k
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_o[k]   <= '0;
            data_o[k] <= '0;
            len_o[k]  <= '0;
            prio_o[k] <= '0;
         end else if (hit_wr) begin
            id_o[k]   <= wr_id;
            data_o[k] <= wr_data;
            len_o[k]  <= wr_len;
            prio_o[k] <= wr_prio;
         end
      end

      // row k of the age matrix: bit j set means slot k was queued before slot j
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            older_o[k] <= '0;
         end else if (wr_en && wr_alloc) begin
            if (wr_slot == SLOT_W'(k)) begin
               older_o[k] <= '0;
            end else begin
               older_o[k][wr_slot] <= valid_o[k];
            end
         end
      end
   end

endmodule

// File: rtl/can_txq_match.sv
module can_txq_match #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ID_W      = 11,
   parameter int unsigned SLOT_W    = 2
) (
   input  logic [NUM_SLOTS-1:0] valid_i,
   input  logic [NUM_SLOTS-1:0] lock_i,
   input  logic [NUM_SLOTS-1:0] excl_i,
   input  logic [ID_W-1:0]      id_i    [NUM_SLOTS],
   input  logic [NUM_SLOTS-1:0] older_i [NUM_SLOTS],
   input  logic [ID_W-1:0]      sub_id,
   input  logic                 sub_replace,
   output logic                 hit_o,
   output logic [SLOT_W-1:0]    hit_slot_o,
   output logic                 free_any_o,
   output logic [SLOT_W-1:0]    free_slot_o
);

   logic [NUM_SLOTS-1:0] cand;
   logic [NUM_SLOTS-1:0] newest;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cand
      assign cand[i] = sub_replace && valid_i[i] && !lock_i[i] && !excl_i[i]
                       && (id_i[i] == sub_id);
   end

   // the newest candidate is the one that is older than no other candidate
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_newest
      logic [NUM_SLOTS-1:0] beaten;
      for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_pair
         assign beaten[j] = (i != j) && cand[j] && older_i[i][j];
      end
      assign newest[i] = cand[i] && !(|beaten);
   end

   always_comb begin
      hit_o      = 1'b0;
      hit_slot_o = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (newest[i]) begin
            hit_o      = 1'b1;
            hit_slot_o = SLOT_W'(i);
         end
      end
   end

   always_comb begin
      free_any_o  = 1'b0;
      free_slot_o = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            free_any_o  = 1'b1;
            free_slot_o = SLOT_W'(i);
         end
      end
   end

endmodule

// File: rtl/can_txq_arbiter.sv
module can_txq_arbiter
   import can_txq_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ID_W      = 11,
   parameter int unsigned PRIO_W    = 8,
   parameter int unsigned SLOT_W    = 2
) (
   input  txq_mode_e            mode_i,
   input  logic [NUM_SLOTS-1:0] valid_i,
   input  logic [NUM_SLOTS-1:0] lock_i,
   input  logic [ID_W-1:0]      id_i    [NUM_SLOTS],
   input  logic [PRIO_W-1:0]    prio_i  [NUM_SLOTS],
   input  logic [NUM_SLOTS-1:0] older_i [NUM_SLOTS],
   output logic                 pick_valid_o,
   output logic [SLOT_W-1:0]    pick_slot_o
);

   localparam int unsigned PAIRS = NUM_SLOTS * NUM_SLOTS;

   function automatic logic wins_f(
      input txq_mode_e         m,
      input logic [ID_W-1:0]   ida,
      input logic [ID_W-1:0]   idb,
      input logic [PRIO_W-1:0] pra,
      input logic [PRIO_W-1:0] prb,
      input logic              a_older,
      input logic              a_lower
   );
      logic id_first;
      id_first = (ida < idb) || ((ida == idb) && a_older);
      case (m)
         TXQ_ARRIVAL: return a_older;
         TXQ_IDPRIO:  return id_first;
         TXQ_SLOTORD: return a_lower;
         default:     return (pra < prb) || ((pra == prb) && id_first);
      endcase
   endfunction

   logic [PAIRS-1:0]     beats;
   logic [PAIRS-1:0]     block;
   logic [PAIRS-1:0]     lose;
   logic [NUM_SLOTS-1:0] elig;
   logic [NUM_SLOTS-1:0] win;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
      for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_col
         assign beats[i*NUM_SLOTS+j] = wins_f(mode_i, id_i[i], id_i[j], prio_i[i], prio_i[j],
                                              older_i[i][j], 1'(i < j));
         // an earlier frame with the same identifier holds this one back
         assign block[i*NUM_SLOTS+j] = (i != j) && valid_i[j] && (id_i[j] == id_i[i])
                                       && older_i[j][i];
      end
      assign elig[i] = valid_i[i] && !lock_i[i] && !(|block[i*NUM_SLOTS +: NUM_SLOTS]);
   end

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_win
      for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_cmp
         assign lose[i*NUM_SLOTS+j] = (i != j) && elig[j] && !beats[i*NUM_SLOTS+j];
      end
      assign win[i] = elig[i] && !(|lose[i*NUM_SLOTS +: NUM_SLOTS]);
   end

   always_comb begin
      pick_valid_o = |win;
      pick_slot_o  = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (win[i]) pick_slot_o = SLOT_W'(i);
      end
   end

endmodule

// File: rtl/can_txq_sched.sv
module can_txq_sched
   import can_txq_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ID_W      = 11,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned LEN_W     = 4,
   parameter int unsigned PRIO_W    = 8,
   localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            cfg_mode,
   input  logic                  sub_valid,
   input  logic [ID_W-1:0]       sub_id,
   input  logic [DATA_W-1:0]     sub_data,
   input  logic [LEN_W-1:0]      sub_len,
   input  logic [PRIO_W-1:0]     sub_prio,
   input  logic                  sub_replace,
   output logic                  sub_busy,
   output logic                  tx_valid,
   output logic [SLOT_W-1:0]     tx_slot,
   output logic [ID_W-1:0]       tx_id,
   output logic [DATA_W-1:0]     tx_data,
   output logic [LEN_W-1:0]      tx_len,
   input  logic                  ctl_grant,
   input  logic                  ctl_done,
   input  logic                  ctl_abort,
   output logic [NUM_SLOTS-1:0]  pending,
   output logic                  full,
   output logic [1:0]            cur_mode
);

   if (NUM_SLOTS < 2 || NUM_SLOTS > 32) begin : g_bad_slots
      $error("can_txq_sched: NUM_SLOTS must be within 2..32");
   end
   if (ID_W < 1 || DATA_W < 1 || LEN_W < 1 || PRIO_W < 1) begin : g_bad_width
      $error("can_txq_sched: field widths must be at least one bit");
   end

   logic [NUM_SLOTS-1:0] valid_q;
   logic [NUM_SLOTS-1:0] lock_q;
   logic [ID_W-1:0]      id_q    [NUM_SLOTS];
   logic [DATA_W-1:0]    data_q  [NUM_SLOTS];
   logic [LEN_W-1:0]     len_q   [NUM_SLOTS];
   logic [PRIO_W-1:0]    prio_q  [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] older_q [NUM_SLOTS];

   txq_mode_e            mode_q;
   logic                 pick_valid;
   logic [SLOT_W-1:0]    pick_slot;
   logic                 locked_any;
   logic                 grant_en;
   logic                 free_en;
   logic [NUM_SLOTS-1:0] grant_mask;
   logic                 hit;
   logic [SLOT_W-1:0]    hit_slot;
   logic                 free_any;
   logic [SLOT_W-1:0]    free_slot;
   logic                 wr_en;

   // policy register: only loads while nothing is queued
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= TXQ_ARRIVAL;
      end else if (!(|valid_q)) begin
         mode_q <= txq_mode_e'(cfg_mode);
      end
   end

   assign locked_any = |lock_q;
   assign tx_valid   = pick_valid && !locked_any;
   assign grant_en   = tx_valid && ctl_grant;
   assign free_en    = (ctl_done || ctl_abort) && locked_any;
   assign grant_mask = grant_en ? (NUM_SLOTS'(1) << pick_slot) : '0;

   can_txq_arbiter #(
      .NUM_SLOTS (NUM_SLOTS),
      .ID_W      (ID_W),
      .PRIO_W    (PRIO_W),
      .SLOT_W    (SLOT_W)
   ) u_arb (
      .mode_i       (mode_q),
      .valid_i      (valid_q),
      .lock_i       (lock_q),
      .id_i         (id_q),
      .prio_i       (prio_q),
      .older_i      (older_q),
      .pick_valid_o (pick_valid),
      .pick_slot_o  (pick_slot)
   );

   can_txq_match #(
      .NUM_SLOTS (NUM_SLOTS),
      .ID_W      (ID_W),
      .SLOT_W    (SLOT_W)
   ) u_match (
      .valid_i     (valid_q),
      .lock_i      (lock_q),
      .excl_i      (grant_mask),
      .id_i        (id_q),
      .older_i     (older_q),
      .sub_id      (sub_id),
      .sub_replace (sub_replace),
      .hit_o       (hit),
      .hit_slot_o  (hit_slot),
      .free_any_o  (free_any),
      .free_slot_o (free_slot)
   );

   assign wr_en    = sub_valid && (hit || free_any);
   assign sub_busy = sub_valid && !hit && !free_any;

   can_txq_store #(
      .NUM_SLOTS (NUM_SLOTS),
      .ID_W      (ID_W),
      .DATA_W    (DATA_W),
      .LEN_W     (LEN_W),
      .PRIO_W    (PRIO_W),
      .SLOT_W    (SLOT_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_alloc   (!hit),
      .wr_slot    (hit ? hit_slot : free_slot),
      .wr_id      (sub_id),
      .wr_data    (sub_data),
      .wr_len     (sub_len),
      .wr_prio    (sub_prio),
      .grant_en   (grant_en),
      .grant_slot (pick_slot),
      .free_en    (free_en),
      .valid_o    (valid_q),
      .lock_o     (lock_q),
      .id_o       (id_q),
      .data_o     (data_q),
      .len_o      (len_q),
      .prio_o     (prio_q),
      .older_o    (older_q)
   );

   assign tx_slot  = pick_slot;
   assign tx_id    = id_q[pick_slot];
   assign tx_data  = data_q[pick_slot];
   assign tx_len   = len_q[pick_slot];
   assign pending  = valid_q;
   assign full     = !free_any;
   assign cur_mode = mode_q;

endmodule

// File: rtl/can_txq_sched_chk.sv
module can_txq_sched_chk #(
   parameter int unsigned NUM_SLOTS = 4,
   localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sub_busy,
   input logic                 tx_valid,
   input logic [SLOT_W-1:0]    tx_slot,
   input logic                 ctl_grant,
   input logic                 ctl_done,
   input logic                 ctl_abort,
   input logic [NUM_SLOTS-1:0] pending,
   input logic                 full,
   input logic [1:0]           cur_mode
);

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (pending == '0) && !tx_valid && (cur_mode == 2'd0));

   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|pending) |=> (cur_mode == $past(cur_mode)));

   p_busy_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sub_busy |-> full);

   p_busy_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_busy && !ctl_done && !ctl_abort) |=> (pending == $past(pending)));

   p_offer_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> pending[tx_slot]);

   p_grant_locks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && ctl_grant) |=> !tx_valid && pending[$past(tx_slot)]);

endmodule

bind can_txq_sched can_txq_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sub_busy  (sub_busy),
   .tx_valid  (tx_valid),
   .tx_slot   (tx_slot),
   .ctl_grant (ctl_grant),
   .ctl_done  (ctl_done),
   .ctl_abort (ctl_abort),
   .pending   (pending),
   .full      (full),
   .cur_mode  (cur_mode)
);

// File: tb/can_txq_sched_tb_top.sv
module can_txq_sched_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N      = 4;
   localparam int ID_W   = 11;
   localparam int DATA_W = 64;
   localparam int LEN_W  = 4;
   localparam int PRIO_W = 8;
   localparam int SLOT_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cfg_mode = '0;
   logic              sub_valid = 1'b0;
   logic [ID_W-1:0]   sub_id = '0;
   logic [DATA_W-1:0] sub_data = '0;
   logic [LEN_W-1:0]  sub_len = '0;
   logic [PRIO_W-1:0] sub_prio = '0;
   logic              sub_replace = 1'b0;
   logic              sub_busy;
   logic              tx_valid;
   logic [SLOT_W-1:0] tx_slot;
   logic [ID_W-1:0]   tx_id;
   logic [DATA_W-1:0] tx_data;
   logic [LEN_W-1:0]  tx_len;
   logic              ctl_grant = 1'b0;
   logic              ctl_done = 1'b0;
   logic              ctl_abort = 1'b0;
   logic [N-1:0]      pending;
   logic              full;
   logic [1:0]        cur_mode;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_txq_sched #(
      .NUM_SLOTS (N), .ID_W (ID_W), .DATA_W (DATA_W), .LEN_W (LEN_W), .PRIO_W (PRIO_W)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cfg_mode (cfg_mode),
      .sub_valid (sub_valid), .sub_id (sub_id), .sub_data (sub_data),
      .sub_len (sub_len), .sub_prio (sub_prio), .sub_replace (sub_replace),
      .sub_busy (sub_busy), .tx_valid (tx_valid), .tx_slot (tx_slot),
      .tx_id (tx_id), .tx_data (tx_data), .tx_len (tx_len),
      .ctl_grant (ctl_grant), .ctl_done (ctl_done), .ctl_abort (ctl_abort),
      .pending (pending), .full (full), .cur_mode (cur_mode)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model of the queue
   bit                mv   [N];
   bit                mlk  [N];
   logic [ID_W-1:0]   mid  [N];
   logic [DATA_W-1:0] mdat [N];
   logic [LEN_W-1:0]  mlen [N];
   logic [PRIO_W-1:0] mpr  [N];
   int                mseq [N];
   int                seqc = 0;
   logic [1:0]        mmode = 2'd0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] m_pend();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = mv[i];
      return v;
   endfunction

   function automatic bit m_anylk();
      for (int i = 0; i < N; i++) if (mlk[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit m_elig(input int i);
      if (!mv[i] || mlk[i]) return 1'b0;
      for (int j = 0; j < N; j++)
         if (j != i && mv[j] && mid[j] == mid[i] && mseq[j] < mseq[i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit m_better(input int i, input int j);
      bit idf;
      idf = (mid[i] < mid[j]) || (mid[i] == mid[j] && mseq[i] < mseq[j]);
      case (mmode)
         2'd0:    return mseq[i] < mseq[j];
         2'd1:    return idf;
         2'd2:    return i < j;
         default: return (mpr[i] < mpr[j]) || (mpr[i] == mpr[j] && idf);
      endcase
   endfunction

   function automatic int m_pick();
      int best;
      best = -1;
      if (m_anylk()) return -1;
      for (int i = 0; i < N; i++)
         if (m_elig(i) && (best < 0 || m_better(i, best))) best = i;
      return best;
   endfunction

   function automatic int m_hit(input logic [ID_W-1:0] id, input bit rep, input int gslot);
      int best;
      best = -1;
      if (!rep) return -1;
      for (int i = 0; i < N; i++)
         if (mv[i] && !mlk[i] && i != gslot && mid[i] == id && (best < 0 || mseq[i] > mseq[best]))
            best = i;
      return best;
   endfunction

   function automatic int m_free();
      for (int i = 0; i < N; i++) if (!mv[i]) return i;
      return -1;
   endfunction

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'd0:    return "R5 R10 arrival";
         2'd1:    return "R6 R10 identifier";
         2'd2:    return "R7 R10 slot";
         default: return "R8 R10 local priority";
      endcase
   endfunction

   // one clock cycle: drive at falling edge, check offer and busy, advance model, check state
   task automatic step(input bit sv, input logic [ID_W-1:0] id, input logic [DATA_W-1:0] dat,
                       input logic [LEN_W-1:0] len, input logic [PRIO_W-1:0] pr, input bit rep,
                       input bit g, input bit d, input bit a, input logic [1:0] md);
      int p, gs, h, fk;
      bit fl;
      sub_valid = sv; sub_id = id; sub_data = dat; sub_len = len; sub_prio = pr;
      sub_replace = rep; ctl_grant = g; ctl_done = d; ctl_abort = a; cfg_mode = md;
      #1;
      p = m_pick();
      check({mode_req(mmode), " R11 tx_valid"}, 64'(tx_valid), 64'(p >= 0));
      if (p >= 0) begin
         check({mode_req(mmode), " tx_slot"}, 64'(tx_slot), 64'(p));
         check({mode_req(mmode), " tx_id"}, 64'(tx_id), 64'(mid[p]));
         check({mode_req(mmode), " R9 tx_data"}, tx_data, mdat[p]);
         check({mode_req(mmode), " tx_len"}, 64'(tx_len), 64'(mlen[p]));
      end
      gs = (g && p >= 0) ? p : -1;
      h  = m_hit(id, rep, gs);
      fl = &m_pend();
      fk = m_free();
      check("R4 sub_busy", 64'(sub_busy), 64'(sv && h < 0 && fl));
      if (m_pend() == '0) mmode = md;
      if ((d || a) && m_anylk())
         for (int i = 0; i < N; i++) if (mlk[i]) begin mv[i] = 1'b0; mlk[i] = 1'b0; end
      if (gs >= 0) mlk[gs] = 1'b1;
      if (sv && (h >= 0 || !fl)) begin
         int k;
         k = (h >= 0) ? h : fk;
         mid[k] = id; mdat[k] = dat; mlen[k] = len; mpr[k] = pr;
         if (h < 0) begin
            mv[k] = 1'b1; mlk[k] = 1'b0; mseq[k] = seqc; seqc++;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check("R3 R9 R11 pending", 64'(pending), 64'(m_pend()));
      check("R3 full", 64'(full), 64'(&m_pend()));
      check("R2 cur_mode", 64'(cur_mode), 64'(mmode));
   endtask

   task automatic idle(input bit g, input bit d, input bit a, input logic [1:0] md);
      step(1'b0, '0, '0, '0, '0, 1'b0, g, d, a, md);
   endtask

   task automatic drain(input logic [1:0] md);
      for (int it = 0; it < 40 && m_pend() != '0; it++) begin
         idle(1'b1, 1'b0, 1'b0, md);
         idle(1'b0, 1'b1, 1'b0, md);
      end
   endtask

   localparam logic [63:0] A1 = 64'h1111_0000_0000_00A1;
   localparam logic [63:0] A2 = 64'h2222_0000_0000_00A2;
   localparam logic [63:0] A3 = 64'h3333_0000_0000_00A3;
   localparam logic [63:0] B1 = 64'h4444_0000_0000_00B1;
   localparam logic [63:0] B2 = 64'h5555_0000_0000_00B2;

   initial begin
      for (int i = 0; i < N; i++) begin
         mv[i] = 0; mlk[i] = 0; mid[i] = '0; mdat[i] = '0; mlen[i] = '0; mpr[i] = '0; mseq[i] = 0;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 pending after reset", 64'(pending), 64'd0);
      check("R1 full after reset", 64'(full), 64'd0);
      check("R1 tx_valid after reset", 64'(tx_valid), 64'd0);
      check("R1 cur_mode after reset", 64'(cur_mode), 64'd0);
      rst_n = 1'b1;

      // directed: identifier mode, same-identifier order, replace, lock, busy
      step(1, 11'd9, A1, 4'd8, 8'd0, 0, 0, 0, 0, 2'd1);
      check("R2 mode taken while empty", 64'(cur_mode), 64'd1);
      step(1, 11'd9, A2, 4'd8, 8'd0, 0, 0, 0, 0, 2'd1);
      step(1, 11'd2, B1, 4'd2, 8'd0, 0, 0, 0, 0, 2'd1);
      check("R6 lowest identifier offered", 64'(tx_slot), 64'd2);
      step(1, 11'd9, A3, 4'd8, 8'd0, 1, 0, 0, 0, 2'd1);
      check("R9 replace takes no slot", 64'(pending), 64'b0111);
      idle(1, 0, 0, 2'd1);
      check("R11 no offer while granted", 64'(tx_valid), 64'd0);
      step(1, 11'd2, B2, 4'd2, 8'd0, 1, 0, 0, 0, 2'd1);
      check("R11 locked frame not replaced", 64'(pending), 64'b1111);
      step(1, 11'd7, A2, 4'd1, 8'd0, 0, 0, 0, 0, 2'd1);
      check("R4 refused submit leaves queue", 64'(pending), 64'b1111);
      idle(0, 0, 0, 2'd3);
      check("R2 mode ignored while busy", 64'(cur_mode), 64'd1);
      idle(0, 1, 0, 2'd1);
      check("R11 done frees slot", 64'(pending), 64'b1011);
      check("R6 next lowest identifier", 64'(tx_slot), 64'd3);
      idle(1, 0, 0, 2'd1);
      idle(0, 1, 0, 2'd1);
      check("R10 earlier same-id frame first", tx_data, A1);
      idle(1, 0, 0, 2'd1);
      idle(0, 0, 1, 2'd1);
      check("R11 abort frees slot", 64'(pending), 64'b0010);
      check("R9 replaced payload offered", tx_data, A3);
      drain(2'd2);

      // directed: slot order and local priority
      idle(0, 0, 0, 2'd3);
      step(1, 11'd5, A1, 4'd1, 8'd7, 0, 0, 0, 0, 2'd3);
      step(1, 11'd6, A2, 4'd1, 8'd3, 0, 0, 0, 0, 2'd3);
      step(1, 11'd4, A3, 4'd1, 8'd3, 0, 0, 0, 0, 2'd3);
      check("R8 low priority then low id", 64'(tx_slot), 64'd2);
      drain(2'd2);
      idle(0, 0, 0, 2'd2);
      step(1, 11'd50, A1, 4'd1, 8'd0, 0, 0, 0, 0, 2'd2);
      step(1, 11'd1, A2, 4'd1, 8'd0, 0, 0, 0, 0, 2'd2);
      check("R7 lowest slot offered", 64'(tx_slot), 64'd0);
      drain(2'd0);

      // constrained random phases, one per policy and repeated
      for (int ph = 0; ph < 8; ph++) begin
         logic [1:0] pm;
         pm = 2'(ph % 4);
         drain(pm);
         idle(0, 0, 0, pm);
         for (int c = 0; c < 400; c++) begin
            logic [ID_W-1:0] rid;
            logic [1:0] md;
            rid = ($urandom % 4 == 0) ? ID_W'($urandom % 2048) : ID_W'($urandom % 6);
            md  = ($urandom % 10 == 0) ? 2'($urandom % 4) : pm;
            step(($urandom % 2) == 0, rid, {$urandom, $urandom}, LEN_W'($urandom % 9),
                 PRIO_W'($urandom % 4), ($urandom % 10) < 3, ($urandom % 10) < 4,
                 ($urandom % 4) == 0, ($urandom % 20) == 0, md);
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R1-timeout actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule